// File: doc/BRIEF.md
# Multiplexed-Address Single-Bit Memory

This block is a one-bit-wide memory with a 20-bit address that arrives over only 10 address pins, in two halves. The controller first presents the upper half of the address and pulses the page strobe. The block captures that half in an internal page register and keeps it there. The controller then places the lower half on the same pins and performs the access.

Data moves on a single bidirectional line. On a write-strobe edge, the block stores the value present on the line. While the read control is held, the block drives the stored bit onto the line. At all other times the line is left floating, so that many such devices can share one bus wire.

The full address is 20 bits. The physical array can be made smaller through two width parameters. The cell index then uses only the low bits of each address half, and the remaining bits alias. All strobes are sampled on the system clock, and only their rising edges act.

Top module: `mux_addr_bitram`

## Requirements
- R1: While `rd` is 0 the block leaves `dq` undriven (high impedance).
- R2: A rising edge of `pg_ld`, seen at a clock edge where `pg_ld` is 1 and was 0 at the previous edge, copies `a_pins` into the page register. The page register keeps that value while `pg_ld` stays high and the pins change.
- R3: A rising edge of `wr` stores the value of `dq` into the cell addressed by {page register, `a_pins`}. Holding `wr` high for further cycles stores nothing more.
- R4: While `rd` is 1, `dq` carries the bit stored at {page register, current `a_pins`}, following pin changes without waiting for a clock.
- R5: Cells with the same low pin value but different page values are independent.
- R6: The cell index is {page[HI_KEEP-1:0], pins[LO_KEEP-1:0]}. With the defaults (5 and 5), pins 3 and 35 reach the same cell, and pages 1 and 33 reach the same page.
- R7: Reset clears the page register to 0.
- R8: `rd` and `wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| a_pins | input | 10 | Shared address pins (page half or cell half) |
| pg_ld | input | 1 | Page strobe; its rising edge captures `a_pins` as the upper address |
| wr | input | 1 | Write strobe; its rising edge stores `dq` |
| rd | input | 1 | Read control; enables the output driver onto `dq` |
| dq | inout | 1 | Shared bidirectional data line |

## Verification
The assertions take for granted that the read control and the write strobe are never active together. This is the condition on which the bus turnaround relies. They also assume that `dq` is a resolved logic level whenever a write edge occurs. The stimulus keeps to these conditions: every task raises at most one of `rd` and `wr`. Only the write task drives the data line, and it releases the line before any read begins.

Inputs change only on the falling clock edge. Each strobe therefore produces a clean edge that is sampled once at the next rising edge.

// File: rtl/mux_addr_bitram.sv
module mux_addr_bitram #(
  parameter int PIN_W   = 10,
  parameter int HI_KEEP = 5,
  parameter int LO_KEEP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] a_pins,
  input  logic             pg_ld,
  input  logic             wr,
  input  logic             rd,
  inout  wire              dq
);
  localparam int IDX_W = HI_KEEP + LO_KEEP;
  localparam int CELLS = 1 << IDX_W;

  logic [PIN_W-1:0] page_q;
  logic             pg_ld_q, wr_q;
  logic             cells [CELLS];
  logic [IDX_W-1:0] idx;
  logic             pg_rise, wr_rise, cell_bit;

  assign pg_rise  = pg_ld & ~pg_ld_q;
  assign wr_rise  = wr & ~wr_q;
  assign idx      = {page_q[HI_KEEP-1:0], a_pins[LO_KEEP-1:0]};
  assign cell_bit = cells[idx];
  assign dq       = rd ? cell_bit : 1'bz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      pg_ld_q <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      pg_ld_q <= pg_ld;
      wr_q    <= wr;
      if (pg_rise) page_q <= a_pins;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_rise) cells[idx] <= dq;
  end
endmodule

module mux_addr_bitram_chk #(
  parameter int PIN_W = 10,
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIN_W-1:0] a_pins,
  input logic             pg_ld,
  input logic             wr,
  input logic             rd,
  input logic             dq,
  input logic [PIN_W-1:0] page_q,
  input logic [IDX_W-1:0] idx,
  input logic             cell_bit
);
  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr)); // R8
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ld && !$past(pg_ld)) |=> page_q == $past(a_pins)); // R2
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_ld && !$past(pg_ld)) |=> $stable(page_q)); // R2
  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !$past(wr)) |=> (idx != $past(idx)) || (cell_bit == $past(dq))); // R3
  AST_RST_PAGE: assert property (@(posedge clk) !rst_n |=> page_q == '0); // R7
endmodule

bind mux_addr_bitram mux_addr_bitram_chk #(.PIN_W(PIN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_pins(a_pins), .pg_ld(pg_ld), .wr(wr), .rd(rd),
  .dq(dq), .page_q(page_q), .idx(idx), .cell_bit(cell_bit)
);

// File: tb/sim_mux_addr_bitram.sv
module sim_mux_addr_bitram;
  logic       clk = 0, rst_n = 0, pg_ld = 0, wr = 0, rd = 0;
  logic [9:0] a_pins = '0;
  logic       tb_en = 0, tb_val = 0;
  wire        dq;
  int         checks = 0, errors = 0;
  bit         done = 0;

  assign dq = tb_en ? tb_val : 1'bz;
  always #10 clk = ~clk;

  mux_addr_bitram u0 (.clk(clk), .rst_n(rst_n), .a_pins(a_pins), .pg_ld(pg_ld),
                      .wr(wr), .rd(rd), .dq(dq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_page(input logic [9:0] p);
    @(negedge clk); a_pins = p; pg_ld = 1;
    @(negedge clk); pg_ld = 0;
  endtask

  task automatic write_bit(input logic [9:0] lo, input logic v);
    @(negedge clk); a_pins = lo; tb_en = 1; tb_val = v; wr = 1;
    @(negedge clk); wr = 0; tb_en = 0;
  endtask

  task automatic read_bit(input logic [9:0] lo, output logic v);
    @(negedge clk); a_pins = lo; rd = 1;
    #2 v = dq;
    #2 rd = 0;
  endtask

  task automatic t_release;
    @(negedge clk); rd = 0; tb_en = 0; #1;
    chk("R1 idle", dq, 1'bz);
    write_bit(10'd7, 1'b1);
    #1 chk("R1 after write", dq, 1'bz);
  endtask

  task automatic t_reset_page;
    logic v;
    write_bit(10'd3, 1'b1);
    load_page(10'd0);
    read_bit(10'd3, v); chk("R7 page zero after reset", v, 1'b1);
    write_bit(10'd3, 1'b0);
  endtask

  task automatic t_pattern;
    logic v;
    load_page(10'd2);
    for (int i = 0; i < 8; i++) write_bit(10'(i), 1'(i % 3 == 0));
    for (int i = 0; i < 8; i++) begin
      read_bit(10'(i), v); chk("R4 pattern", v, 1'(i % 3 == 0));
    end
  endtask

  task automatic t_live_pins;
    @(negedge clk); a_pins = 10'd0; rd = 1; #2;
    chk("R4 live pin 0", dq, 1'b1);
    a_pins = 10'd1; #2;
    chk("R4 live pin 1", dq, 1'b0);
    rd = 0;
  endtask

  task automatic t_pages;
    logic v;
    load_page(10'd4); write_bit(10'd9, 1'b1);
    load_page(10'd5); write_bit(10'd9, 1'b0);
    load_page(10'd4); read_bit(10'd9, v); chk("R5 page 4", v, 1'b1);
    load_page(10'd5); read_bit(10'd9, v); chk("R5 page 5", v, 1'b0);
  endtask

  task automatic t_page_hold;
    logic v;
    load_page(10'd6); write_bit(10'd11, 1'b0);
    load_page(10'd7); write_bit(10'd11, 1'b1);
    @(negedge clk); a_pins = 10'd6; pg_ld = 1;
    @(negedge clk); a_pins = 10'd7;
    @(negedge clk); a_pins = 10'd8;
    @(negedge clk); pg_ld = 0;
    read_bit(10'd11, v); chk("R2 held page keeps first value", v, 1'b0);
  endtask

  task automatic t_write_once;
    logic v;
    load_page(10'd9);
    @(negedge clk); a_pins = 10'd12; tb_en = 1; tb_val = 1; wr = 1;
    @(negedge clk); tb_val = 0;
    @(negedge clk); a_pins = 10'd13; tb_val = 1;
    @(negedge clk); wr = 0; tb_en = 0;
    read_bit(10'd12, v); chk("R3 stored at edge", v, 1'b1);
    write_bit(10'd13, 1'b0);
    @(negedge clk); a_pins = 10'd13; tb_en = 1; tb_val = 1; wr = 1;
    @(negedge clk); a_pins = 10'd12; tb_val = 0;
    @(negedge clk); wr = 0; tb_en = 0;
    read_bit(10'd12, v); chk("R3 held strobe no rewrite", v, 1'b1);
    read_bit(10'd13, v); chk("R3 edge cell", v, 1'b1);
  endtask

  task automatic t_alias;
    logic v;
    load_page(10'd1); write_bit(10'd3, 1'b1);
    read_bit(10'd35, v); chk("R6 pin alias", v, 1'b1);
    write_bit(10'd35, 1'b0);
    load_page(10'd33); read_bit(10'd3, v); chk("R6 page alias", v, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_release;
    t_reset_page;
    t_pattern;
    t_live_pins;
    t_pages;
    t_page_hold;
    t_write_once;
    t_alias;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule